// File: doc/BRIEF.md
# Asynchronous SRAM Strobe Controller

This block sits between an internal single-request handshake and an external 32K x 8 asynchronous static RAM. A requester presents an address, a direction and (for writes) a byte; the controller accepts it only while idle, then drives the RAM address, a pair of opposite-polarity chip selects and an active-low write strobe, and times every phase by counting clock cycles. Each timing limit is a parameter in nanoseconds, and the clock period is a parameter too. The controller rounds each limit up to whole cycles.

Writes are controlled by the write strobe. The selects go active one cycle before the strobe falls and stay active one cycle after it rises. The controller turns on its own data driver only after the strobe has been low long enough for the RAM output to go high impedance. It turns the driver off on the same edge that raises the strobe. Reads hold the strobe high, capture the RAM data on the edge that completes the access count, and return it with a one-cycle response pulse. The bidirectional data pins are split into an output byte, an output enable and an input byte; the pad tristate lies outside the block.

Top module: `sram_strobe_ctrl`

## Requirements
- R1: During and after reset the active-low select is 1, the active-high select is 0, the write strobe is 1, the data driver enable is 0, `req_ready` is 1 and `rsp_valid` is 0.
- R2: A read holds both selects active and the write strobe high, captures `ram_dq_in` on the edge RD_CYC cycles after acceptance (9 at the defaults), and presents it on `rsp_rdata` with `rsp_valid` high in the cycle after that edge.
- R3: During a write the strobe stays low for W_LOW cycles (8 at the defaults, never fewer than the pulse-width count), and both selects are active for the whole time the strobe is low.
- R4: The data driver enable is high only while the strobe is low and the RAM is selected, and it rises no sooner than HZ_CYC cycles after the strobe fell (4 at the defaults).
- R5: The RAM address changes only on an edge at which the write strobe is high both before and after the edge.
- R6: The data driver enable has been high for at least DW_CYC cycles (4 at the defaults) when the strobe rises, and it falls on that same edge.
- R7: `req_ready` is high only when idle; a request presented while busy has no effect.
- R8: `rsp_valid` is a single-cycle pulse for each accepted read, and a write produces no pulse.
- R9: Each write puts the requested address and byte on the RAM, so a later read of that address returns the byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 15 | Request address |
| req_wdata | input | 8 | Write byte |
| req_ready | output | 1 | Controller idle, request accepted this cycle if valid |
| rsp_valid | output | 1 | Read data returned (one-cycle pulse) |
| rsp_rdata | output | 8 | Read data |
| ram_addr | output | 15 | RAM address |
| ram_ce_n | output | 1 | RAM select, active low |
| ram_ce | output | 1 | RAM select, active high |
| ram_we_n | output | 1 | RAM write strobe, active low |
| ram_dq_out | output | 8 | Byte to drive onto the data pins |
| ram_dq_oe | output | 1 | Enable for the data pin driver |
| ram_dq_in | input | 8 | Byte sensed on the data pins |

## Verification
The hardest situation to create from the ports is a request that arrives while a write is still in progress. If that request were taken, it would move the address or data under a low strobe. The bench holds a conflicting write request high for several cycles in the middle of a write strobe and drops it before the controller goes idle. It then reads the address back to show the stray byte never landed. A bench RAM model returns a garbage byte until the access time has run out and flags any drive overlap, so early capture and bus contention both show up as data or protocol mismatches.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_STROBE,
    ST_HOLD,
    ST_READ
  } seq_state_t;

  // Round a time in ns up to whole clock cycles, at least one.
  function automatic int cyc_of(input int ns, input int period_ns);
    int c;
    c = (ns + period_ns - 1) / period_ns;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_cyc_timer.sv
module sram_cyc_timer #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  output logic [CNT_W-1:0] count
);
  localparam logic [CNT_W-1:0] TOP = {CNT_W{1'b1}};

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      count <= '0;
    end else if (count != TOP) begin
      count <= count + 1'b1;
    end
  end
endmodule

// File: rtl/sram_rd_capture.sv
module sram_rd_capture #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              take,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dout,
  output logic              strobe
);
  always_ff @(posedge clk) begin
    if (rst) begin
      dout   <= '0;
      strobe <= 1'b0;
    end else begin
      strobe <= take;
      if (take) dout <= din;
    end
  end
endmodule

// File: rtl/sram_strobe_ctrl.sv
module sram_strobe_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int ADDR_W        = 15,
  parameter int DATA_W        = 8,
  parameter int CLK_PERIOD_NS = 8,
  parameter int T_RC_NS       = 70,
  parameter int T_AA_NS       = 70,
  parameter int T_WC_NS       = 70,
  parameter int T_WP_NS       = 55,
  parameter int T_AW_NS       = 50,
  parameter int T_DW_NS       = 30,
  parameter int T_WHZ_NS      = 30
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              req_ready,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic [ADDR_W-1:0] ram_addr,
  output logic              ram_ce_n,
  output logic              ram_ce,
  output logic              ram_we_n,
  output logic [DATA_W-1:0] ram_dq_out,
  output logic              ram_dq_oe,
  input  logic [DATA_W-1:0] ram_dq_in
);
  // Cycle counts derived from the nanosecond limits.
  localparam int HZ_CYC  = cyc_of(T_WHZ_NS, CLK_PERIOD_NS);
  localparam int DW_CYC  = cyc_of(T_DW_NS, CLK_PERIOD_NS);
  localparam int WP_CYC  = cyc_of(T_WP_NS, CLK_PERIOD_NS);
  localparam int AW_CYC  = cyc_of(T_AW_NS, CLK_PERIOD_NS);
  localparam int WC_CYC  = cyc_of(T_WC_NS, CLK_PERIOD_NS);
  localparam int RD_CYC  = imax(cyc_of(T_AA_NS, CLK_PERIOD_NS),
                                cyc_of(T_RC_NS, CLK_PERIOD_NS));
  // Strobe-low length: pulse width, turnaround plus data setup,
  // address-valid window (setup cycle counts) and total cycle (setup + hold).
  localparam int W_LOW   = imax(imax(WP_CYC, HZ_CYC + DW_CYC),
                                imax(AW_CYC - 1, WC_CYC - 2));
  localparam int CNT_MAX = imax(W_LOW, RD_CYC);
  localparam int CNT_W   = $clog2(CNT_MAX + 1);

  localparam logic [CNT_W-1:0] HZ_LAST = CNT_W'(HZ_CYC - 1);
  localparam logic [CNT_W-1:0] WL_LAST = CNT_W'(W_LOW - 1);
  localparam logic [CNT_W-1:0] RD_LAST = CNT_W'(RD_CYC - 1);

  seq_state_t        state, state_nxt;
  logic [CNT_W-1:0]  cnt;
  logic              sel_q, we_n_q, oe_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdat_q;
  logic              take;

  always_comb begin
    state_nxt = state;
    case (state)
      ST_IDLE:   if (req_valid) state_nxt = req_write ? ST_SETUP : ST_READ;
      ST_SETUP:  state_nxt = ST_STROBE;
      ST_STROBE: if (cnt == WL_LAST) state_nxt = ST_HOLD;
      ST_HOLD:   state_nxt = ST_IDLE;
      ST_READ:   if (cnt == RD_LAST) state_nxt = ST_IDLE;
      default:   state_nxt = ST_IDLE;
    endcase
  end

  assign take = (state == ST_READ) && (cnt == RD_LAST);

  sram_cyc_timer #(.CNT_W(CNT_W)) u_timer (
    .clk   (clk),
    .rst   (rst),
    .clr   (state_nxt != state),
    .count (cnt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= ST_IDLE;
      sel_q  <= 1'b0;
      we_n_q <= 1'b1;
      oe_q   <= 1'b0;
      addr_q <= '0;
      wdat_q <= '0;
    end else begin
      state <= state_nxt;
      case (state)
        ST_IDLE: begin
          if (req_valid) begin
            addr_q <= req_addr;
            wdat_q <= req_wdata;
            sel_q  <= 1'b1;
          end
        end
        ST_SETUP:  we_n_q <= 1'b0;
        ST_STROBE: begin
          if (cnt == HZ_LAST) oe_q <= 1'b1;
          if (cnt == WL_LAST) begin
            we_n_q <= 1'b1;
            oe_q   <= 1'b0;
          end
        end
        ST_HOLD:   sel_q <= 1'b0;
        ST_READ:   if (cnt == RD_LAST) sel_q <= 1'b0;
        default:   sel_q <= 1'b0;
      endcase
    end
  end

  sram_rd_capture #(.DATA_W(DATA_W)) u_cap (
    .clk    (clk),
    .rst    (rst),
    .take   (take),
    .din    (ram_dq_in),
    .dout   (rsp_rdata),
    .strobe (rsp_valid)
  );

  assign req_ready  = (state == ST_IDLE);
  assign ram_addr   = addr_q;
  assign ram_ce_n   = ~sel_q;
  assign ram_ce     = sel_q;
  assign ram_we_n   = we_n_q;
  assign ram_dq_out = wdat_q;
  assign ram_dq_oe  = oe_q;
endmodule

// File: rtl/sram_strobe_ctrl_chk.sv
module sram_strobe_ctrl_chk
  import sram_ctrl_pkg::*;
#(
  parameter int ADDR_W        = 15,
  parameter int CLK_PERIOD_NS = 8,
  parameter int T_WP_NS       = 55,
  parameter int T_DW_NS       = 30,
  parameter int T_WHZ_NS      = 30
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic              req_ready,
  input logic              rsp_valid,
  input logic [ADDR_W-1:0] ram_addr,
  input logic              ram_ce_n,
  input logic              ram_ce,
  input logic              ram_we_n,
  input logic              ram_dq_oe
);
  localparam int HZ_CYC = cyc_of(T_WHZ_NS, CLK_PERIOD_NS);
  localparam int DW_CYC = cyc_of(T_DW_NS, CLK_PERIOD_NS);
  localparam int WP_CYC = cyc_of(T_WP_NS, CLK_PERIOD_NS);

  int unsigned we_run, oe_run;

  always_ff @(posedge clk) begin
    if (rst) begin
      we_run <= 0;
      oe_run <= 0;
    end else begin
      if (!ram_we_n) begin
        if (we_run < 1000) we_run <= we_run + 1;
      end else begin
        we_run <= 0;
      end
      if (ram_dq_oe) begin
        if (oe_run < 1000) oe_run <= oe_run + 1;
      end else begin
        oe_run <= 0;
      end
    end
  end

  a_r1_reset_idle: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (ram_ce_n && !ram_ce && ram_we_n && !ram_dq_oe && req_ready && !rsp_valid));

  a_r2_read_strobe_high: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> (ram_we_n && $past(ram_we_n)));

  a_r3_we_width: assert property (@(posedge clk) disable iff (rst)
    $rose(ram_we_n) |-> (we_run >= WP_CYC));

  a_r3_selected_under_we: assert property (@(posedge clk) disable iff (rst)
    !ram_we_n |-> (!ram_ce_n && ram_ce));

  a_r4_oe_under_we: assert property (@(posedge clk) disable iff (rst)
    ram_dq_oe |-> (!ram_we_n && !ram_ce_n && ram_ce));

  a_r4_turnaround: assert property (@(posedge clk) disable iff (rst)
    $rose(ram_dq_oe) |-> (we_run >= HZ_CYC));

  a_r5_addr_quiet: assert property (@(posedge clk) disable iff (rst)
    !$stable(ram_addr) |-> (ram_we_n && $past(ram_we_n)));

  a_r6_data_setup: assert property (@(posedge clk) disable iff (rst)
    $rose(ram_we_n) |-> (oe_run >= DW_CYC && !ram_dq_oe));

  a_r7_single_accept: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> !req_ready);

  a_r8_rsp_pulse: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |=> !rsp_valid);
endmodule

bind sram_strobe_ctrl sram_strobe_ctrl_chk #(
  .ADDR_W        (ADDR_W),
  .CLK_PERIOD_NS (CLK_PERIOD_NS),
  .T_WP_NS       (T_WP_NS),
  .T_DW_NS       (T_DW_NS),
  .T_WHZ_NS      (T_WHZ_NS)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .rsp_valid (rsp_valid),
  .ram_addr  (ram_addr),
  .ram_ce_n  (ram_ce_n),
  .ram_ce    (ram_ce),
  .ram_we_n  (ram_we_n),
  .ram_dq_oe (ram_dq_oe)
);

// File: tb/sram_strobe_ctrl_test.sv
module sram_strobe_ctrl_test;
  // Expected cycle counts at an 8 ns clock.
  localparam int RD_CYC = 9;
  localparam int W_LOW  = 8;
  localparam int HZ_CYC = 4;
  localparam int DW_CYC = 4;
  localparam int WP_CYC = 7;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [14:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic        req_ready, rsp_valid, ram_ce_n, ram_ce, ram_we_n, ram_dq_oe;
  logic [7:0]  rsp_rdata, ram_dq_out;
  logic [7:0]  ram_dq_in = 8'hEE;
  logic [14:0] ram_addr;

  int vectors = 0, fails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  sram_strobe_ctrl uut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .ram_addr(ram_addr),
    .ram_ce_n(ram_ce_n), .ram_ce(ram_ce), .ram_we_n(ram_we_n),
    .ram_dq_out(ram_dq_out), .ram_dq_oe(ram_dq_oe), .ram_dq_in(ram_dq_in)
  );

  function automatic logic [7:0] init_byte(input logic [14:0] a);
    return a[7:0] ^ {1'b0, a[14:8]};
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // ---------------- RAM model with protocol checks ----------------
  logic [7:0]  ram_mem [int];
  logic [7:0]  shadow  [int];
  logic [22:0] exp_wq[$];
  logic [7:0]  exp_rq[$];
  int rd_cnt = 0, we_cnt = 0, oe_cnt = 0;
  logic        prev_wlow = 0, prev_we_n = 1;
  logic [14:0] prev_addr = '0;
  logic [7:0]  last_d = '0;

  always @(negedge clk) begin
    if (!rst) begin
      logic selw, selr;
      selw = !ram_ce_n && ram_ce && !ram_we_n;
      selr = !ram_ce_n && ram_ce && ram_we_n;
      // R5: address only moves with the strobe high on both sides
      if (ram_addr != prev_addr)
        check(ram_we_n && prev_we_n, "R5 addr moved under low strobe", ram_we_n, 1);
      // R4: driver only after turnaround, only while strobe low and selected
      if (ram_dq_oe) begin
        check(selw && we_cnt >= HZ_CYC, "R4 driver timing", we_cnt, HZ_CYC);
        last_d = ram_dq_out;
      end
      if (prev_wlow && ram_we_n) begin
        logic [22:0] e;
        check(we_cnt >= W_LOW && we_cnt >= WP_CYC, "R3 strobe width", we_cnt, W_LOW);
        check(!ram_ce_n && ram_ce, "R3 selects after strobe", ram_ce, 1);
        check(oe_cnt >= DW_CYC && !ram_dq_oe, "R6 data setup", oe_cnt, DW_CYC);
        ram_mem[int'(ram_addr)] = last_d;
        if (exp_wq.size() == 0) begin
          check(0, "R9 unexpected write", ram_addr, 0);
        end else begin
          e = exp_wq.pop_front();
          check({ram_addr, last_d} == e, "R9 write addr/data", {ram_addr, last_d}, e);
        end
      end
      we_cnt    = selw ? we_cnt + 1 : 0;
      oe_cnt    = ram_dq_oe ? oe_cnt + 1 : 0;
      rd_cnt    = selr ? rd_cnt + 1 : 0;
      prev_wlow = selw;
      prev_we_n = ram_we_n;
      prev_addr = ram_addr;
      if (selr && rd_cnt >= RD_CYC)
        ram_dq_in = ram_mem.exists(int'(ram_addr)) ? ram_mem[int'(ram_addr)] : init_byte(ram_addr);
      else
        ram_dq_in = 8'hEE;
    end
  end

  // ---------------- read scoreboard monitor ----------------
  always @(negedge clk) begin
    if (!rst && rsp_valid) begin
      logic [7:0] e;
      if (exp_rq.size() == 0) begin
        check(0, "R8 unexpected response", rsp_rdata, 0);
      end else begin
        e = exp_rq.pop_front();
        check(rsp_rdata == e, "R2/R9 read data", rsp_rdata, e);
      end
    end
  end

  // ---------------- driver ----------------
  task automatic issue_write(input logic [14:0] a, input logic [7:0] d);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1; req_write = 1; req_addr = a; req_wdata = d;
    exp_wq.push_back({a, d});
    shadow[int'(a)] = d;
    @(negedge clk);
    req_valid = 0;
    check(!req_ready, "R7 busy after write accept", req_ready, 0);
  endtask

  task automatic issue_read(input logic [14:0] a);
    int n;
    bit busy_ok;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1; req_write = 0; req_addr = a; req_wdata = 8'h00;
    exp_rq.push_back(shadow.exists(int'(a)) ? shadow[int'(a)] : init_byte(a));
    @(negedge clk);
    req_valid = 0;
    n = 1;
    busy_ok = 1;
    while (!rsp_valid && n < 40) begin
      if (req_ready) busy_ok = 0;
      @(negedge clk);
      n++;
    end
    check(n == RD_CYC + 1, "R2 read latency", n, RD_CYC + 1);
    check(busy_ok, "R7 busy during read", busy_ok, 1);
    @(negedge clk);
    check(!rsp_valid, "R8 response single cycle", rsp_valid, 0);
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired actual=%0d expected=0", 1);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  // ---------------- stimulus ----------------
  initial begin
    bit rsp_seen;
    repeat (4) @(negedge clk);
    // R1: reset state
    check(ram_ce_n && !ram_ce && ram_we_n && !ram_dq_oe && req_ready && !rsp_valid,
          "R1 state during reset", {ram_ce_n, ram_ce, ram_we_n, ram_dq_oe, req_ready, rsp_valid}, 6'b101010);
    rst = 0;
    @(negedge clk);
    check(ram_ce_n && !ram_ce && ram_we_n && !ram_dq_oe && req_ready && !rsp_valid,
          "R1 state after reset", {ram_ce_n, ram_ce, ram_we_n, ram_dq_oe, req_ready, rsp_valid}, 6'b101010);

    issue_read(15'h0000);             // R2: unwritten cell returns model contents
    issue_write(15'h0000, 8'hA5);     // boundary addresses
    issue_write(15'h7FFF, 8'h5A);
    issue_write(15'h1234, 8'h3C);
    issue_read(15'h7FFF);
    issue_read(15'h0000);
    issue_read(15'h1234);
    issue_write(15'h4001, 8'hFF);     // write immediately followed by read
    issue_read(15'h4001);

    // R7: a conflicting request during a write has no effect
    issue_write(15'h0100, 8'h11);
    req_valid = 1; req_write = 1; req_addr = 15'h0100; req_wdata = 8'h99;
    for (int i = 0; i < 3; i++) begin
      check(!req_ready, "R7 ready low while writing", req_ready, 0);
      @(negedge clk);
    end
    req_valid = 0;
    issue_read(15'h0100);

    // R8: writes produce no response pulse
    rsp_seen = 0;
    fork
      issue_write(15'h2222, 8'h77);
      begin
        repeat (14) begin
          @(negedge clk);
          if (rsp_valid) rsp_seen = 1;
        end
      end
    join
    check(!rsp_seen, "R8 no response for write", rsp_seen, 0);

    // R9: pattern sweep, writes then reads
    for (int i = 0; i < 12; i++)
      issue_write(15'(i * 2731 + 5), 8'(i * 37 + 1));
    for (int i = 11; i >= 0; i--)
      issue_read(15'(i * 2731 + 5));
    issue_read(15'h2222);

    repeat (20) @(negedge clk);
    check(exp_wq.size() == 0, "R9 all writes seen", exp_wq.size(), 0);
    check(exp_rq.size() == 0, "R2 all reads answered", exp_rq.size(), 0);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule